// File: doc/BRIEF.md
# Constant Load Verification Buffer

This block keeps a small, fully associative record of loads that a value predictor has marked as constant. Each record holds the load's data address and the index of the predictor entry that produced the prediction. Stores snoop the buffer by address, and every record at a stored-to address is dropped, because that location may now hold a different value.

When a constant load reaches verification, the pipeline queries the buffer with the load's address and predictor index. One cycle later the block returns either a hit, in which case the load commits normally, or a squash request, in which case the load and everything younger must be discarded.

Inserting a pair that is already held refreshes it and does not create a duplicate. When no slot is free, the insert replaces the record that was written or refreshed longest ago. A full flag reports when every slot holds a valid record.

Top module: `const_load_guard`

## Requirements
- R1: After reset no record is valid, and `full_o`, `qry_done_o`, `qry_hit_o` and `squash_o` are all low.
- R2: A query whose address and index both equal those of a valid record returns `qry_done_o`=1 and `qry_hit_o`=1 with `squash_o`=0.
- R3: A query with no valid record matching both address and index returns `qry_done_o`=1, `squash_o`=1 and `qry_hit_o`=0. A record with the same address but a different index does not match.
- R4: A store with `st_valid_i`=1 invalidates every record whose address equals `st_addr_i`, whatever its index. Later queries for those records miss.
- R5: If a store and a query for the same address arrive in the same cycle, the query reports a miss.
- R6: `full_o` is high exactly when all DEPTH (default 32) records are valid.
- R7: An insert that finds no free slot replaces the record that was inserted or refreshed longest ago.
- R8: Inserting an address and index pair that is already valid uses no new slot, and makes that record the most recent one for replacement order.
- R9: The query result appears in the cycle after the request. `qry_done_o` is low in any cycle that follows a cycle without a query.
- R10: If an insert and a store to the same address arrive in the same cycle, the inserted pair is valid afterwards.
- R11: An insert that has a free slot (counting slots freed by a store in the same cycle) takes that slot and removes no valid record.
- R12: A query sees the buffer as it was before any insert in the same cycle, so the pair being inserted is not yet a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ins_valid_i | input | 1 | Insert request |
| ins_addr_i | input | 64 | Data address to record |
| ins_idx_i | input | 10 | Predictor entry index to record |
| st_valid_i | input | 1 | Store snoop request |
| st_addr_i | input | 64 | Store data address |
| qry_valid_i | input | 1 | Verification request |
| qry_addr_i | input | 64 | Address of the constant load |
| qry_idx_i | input | 10 | Predictor index of the constant load |
| qry_done_o | output | 1 | Result valid, one cycle after the request |
| qry_hit_o | output | 1 | Verification passed |
| squash_o | output | 1 | Verification failed; squash required |
| full_o | output | 1 | All slots hold valid records |

## Verification
The hardest case to reach is eviction once the buffer holds records of mixed age. The buffer must first be filled completely, and a refresh must reorder the records before the first replacement, so that the oldest record is not simply the one in the lowest slot. The directed stimulus fills 31 slots, refreshes the first pair, fills the last slot and then inserts two new pairs. It then queries both the evicted and the surviving records. A long random phase follows over a narrow set of addresses and indices. There, stores, inserts and queries collide often in the same cycle and the buffer repeatedly fills and drains, while an arithmetic reference model that orders records by timestamp predicts every result and the full flag.

// File: rtl/clg_pkg.sv
package clg_pkg;
  localparam int unsigned DEF_DEPTH  = 32;
  localparam int unsigned DEF_ADDR_W = 64;
  localparam int unsigned DEF_IDX_W  = 10;

  typedef enum logic [1:0] {
    RES_NONE   = 2'b00,
    RES_HIT    = 2'b01,
    RES_SQUASH = 2'b10
  } qry_res_e;
endpackage

// File: rtl/clg_cam.sv
module clg_cam #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned IDX_W  = 10,
  localparam int unsigned SLOT_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              kill_en_i,
  input  logic [ADDR_W-1:0] kill_addr_i,
  input  logic [ADDR_W-1:0] qry_addr_i,
  input  logic [IDX_W-1:0]  qry_idx_i,
  output logic [DEPTH-1:0]  valid_o,
  output logic [DEPTH-1:0]  wr_match_o,
  output logic [DEPTH-1:0]  kill_vec_o,
  output logic [DEPTH-1:0]  qry_match_o
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic              vld_q;
    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  idx_q;
    logic              sel;

    assign sel = wr_en_i && (wr_slot_i == SLOT_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            vld_q <= 1'b0;
      else if (sel)           vld_q <= 1'b1;   // insert beats same-cycle store
      else if (kill_vec_o[g]) vld_q <= 1'b0;
    end

    always_ff @(posedge clk_i) begin
      if (sel) begin
        addr_q <= wr_addr_i;
        idx_q  <= wr_idx_i;
      end
    end

    assign valid_o[g]     = vld_q;
    assign wr_match_o[g]  = vld_q && (addr_q == wr_addr_i) && (idx_q == wr_idx_i);
    assign kill_vec_o[g]  = kill_en_i && vld_q && (addr_q == kill_addr_i);
    assign qry_match_o[g] = vld_q && (addr_q == qry_addr_i) && (idx_q == qry_idx_i);

    // R4
    kill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      kill_vec_o[g] && !sel |=> !vld_q);
  end

endmodule

// File: rtl/clg_age.sv
module clg_age #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned SLOT_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              touch_i,
  input  logic [SLOT_W-1:0] touch_slot_i,
  input  logic              all_valid_i,
  output logic [SLOT_W-1:0] oldest_o
);

  // older_q[i][j]: slot i was written before slot j
  logic [DEPTH-1:0][DEPTH-1:0] older_q;
  logic [DEPTH-1:0]            is_old;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      older_q <= '0;
    end else if (touch_i) begin
      for (int j = 0; j < DEPTH; j++) begin
        older_q[touch_slot_i][j] <= 1'b0;
        if (j != int'(touch_slot_i)) older_q[j][touch_slot_i] <= 1'b1;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      is_old[i] = 1'b1;
      for (int j = 0; j < DEPTH; j++)
        if (j != i && !older_q[i][j]) is_old[i] = 1'b0;
    end
  end

  always_comb begin
    oldest_o = '0;
    for (int k = DEPTH - 1; k >= 0; k--)
      if (is_old[k]) oldest_o = SLOT_W'(k);
  end

  // R7
  oldest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_valid_i |-> $onehot(is_old));

endmodule

// File: rtl/const_load_guard.sv
module const_load_guard
  import clg_pkg::*;
#(
  parameter int unsigned DEPTH  = DEF_DEPTH,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned IDX_W  = DEF_IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ins_valid_i,
  input  logic [ADDR_W-1:0] ins_addr_i,
  input  logic [IDX_W-1:0]  ins_idx_i,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic              qry_valid_i,
  input  logic [ADDR_W-1:0] qry_addr_i,
  input  logic [IDX_W-1:0]  qry_idx_i,
  output logic              qry_done_o,
  output logic              qry_hit_o,
  output logic              squash_o,
  output logic              full_o
);

  localparam int unsigned SLOT_W = $clog2(DEPTH);

  logic [DEPTH-1:0]  valid_vec, wr_match, kill_vec, qry_match, avail;
  logic [SLOT_W-1:0] free_slot, match_slot, oldest_slot, wr_slot;
  logic              qry_hit;
  qry_res_e          res_q;

  clg_cam #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_cam (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (ins_valid_i),
    .wr_slot_i   (wr_slot),
    .wr_addr_i   (ins_addr_i),
    .wr_idx_i    (ins_idx_i),
    .kill_en_i   (st_valid_i),
    .kill_addr_i (st_addr_i),
    .qry_addr_i  (qry_addr_i),
    .qry_idx_i   (qry_idx_i),
    .valid_o     (valid_vec),
    .wr_match_o  (wr_match),
    .kill_vec_o  (kill_vec),
    .qry_match_o (qry_match)
  );

  clg_age #(.DEPTH(DEPTH)) u_age (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .touch_i      (ins_valid_i),
    .touch_slot_i (wr_slot),
    .all_valid_i  (&valid_vec),
    .oldest_o     (oldest_slot)
  );

  // slots freed by a same-cycle store count as free
  assign avail = ~valid_vec | kill_vec;

  always_comb begin
    free_slot  = '0;
    match_slot = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (avail[k])    free_slot  = SLOT_W'(k);
      if (wr_match[k]) match_slot = SLOT_W'(k);
    end
  end

  always_comb begin
    if (|wr_match)   wr_slot = match_slot;
    else if (|avail) wr_slot = free_slot;
    else             wr_slot = oldest_slot;
  end

  assign qry_hit = (|qry_match) && !(st_valid_i && (st_addr_i == qry_addr_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          res_q <= RES_NONE;
    else if (!qry_valid_i) res_q <= RES_NONE;
    else                  res_q <= qry_hit ? RES_HIT : RES_SQUASH;
  end

  assign qry_done_o = (res_q != RES_NONE);
  assign qry_hit_o  = (res_q == RES_HIT);
  assign squash_o   = (res_q == RES_SQUASH);
  assign full_o     = &valid_vec;

  // R9
  done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qry_valid_i |=> qry_done_o);

  // R2
  res_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qry_done_o |-> $onehot({qry_hit_o, squash_o}));

  // R5
  same_cyc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qry_valid_i && st_valid_i && (st_addr_i == qry_addr_i) |=> squash_o);

  // R8
  no_dup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_i |-> $countones(wr_match) <= 1);

  // R6
  full_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && ins_valid_i && !st_valid_i |=> full_o);

  // R11
  fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_i && !st_valid_i && !full_o && !(|wr_match)
    |=> $countones(valid_vec) == $past($countones(valid_vec)) + 1);

endmodule

// File: tb/const_load_guard_test.sv
module const_load_guard_test;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ins_valid_i = 1'b0;
  logic [63:0] ins_addr_i = '0;
  logic [9:0]  ins_idx_i = '0;
  logic        st_valid_i = 1'b0;
  logic [63:0] st_addr_i = '0;
  logic        qry_valid_i = 1'b0;
  logic [63:0] qry_addr_i = '0;
  logic [9:0]  qry_idx_i = '0;
  logic        qry_done_o, qry_hit_o, squash_o, full_o;

  int errors = 0;
  int checks = 0;

  bit          m_v[DEPTH];
  logic [63:0] m_a[DEPTH];
  logic [9:0]  m_i[DEPTH];
  int          m_s[DEPTH];
  int          seq = 0;

  always #5 clk = ~clk;

  const_load_guard uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .ins_valid_i(ins_valid_i), .ins_addr_i(ins_addr_i), .ins_idx_i(ins_idx_i),
    .st_valid_i(st_valid_i), .st_addr_i(st_addr_i),
    .qry_valid_i(qry_valid_i), .qry_addr_i(qry_addr_i), .qry_idx_i(qry_idx_i),
    .qry_done_o(qry_done_o), .qry_hit_o(qry_hit_o), .squash_o(squash_o), .full_o(full_o)
  );

  function automatic logic [63:0] aa(int n);
    return 64'hC0DE_0000_0000_0000 + 64'(n);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit m_query(logic [63:0] a, logic [9:0] i);
    for (int k = 0; k < DEPTH; k++)
      if (m_v[k] && m_a[k] == a && m_i[k] == i) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int m_count();
    int c = 0;
    for (int k = 0; k < DEPTH; k++) if (m_v[k]) c++;
    return c;
  endfunction

  task automatic m_update(bit iv, logic [63:0] ia, logic [9:0] ii, bit sv, logic [63:0] sa);
    int hitk;
    int slot;
    hitk = -1;
    if (iv) for (int k = 0; k < DEPTH; k++)
      if (m_v[k] && m_a[k] == ia && m_i[k] == ii) hitk = k;
    if (sv) for (int k = 0; k < DEPTH; k++)
      if (m_v[k] && m_a[k] == sa) m_v[k] = 1'b0;
    if (iv) begin
      slot = hitk;
      if (slot < 0) for (int k = 0; k < DEPTH; k++)
        if (!m_v[k] && slot < 0) slot = k;
      if (slot < 0) begin
        slot = 0;
        for (int k = 1; k < DEPTH; k++) if (m_s[k] < m_s[slot]) slot = k;
      end
      m_v[slot] = 1'b1; m_a[slot] = ia; m_i[slot] = ii; m_s[slot] = seq; seq++;
    end
  endtask

  // one cycle of stimulus; checks results right after the edge
  task automatic step(bit iv, logic [63:0] ia, logic [9:0] ii,
                      bit sv, logic [63:0] sa,
                      bit qv, logic [63:0] qa, logic [9:0] qi, string req);
    bit exp_hit;
    @(negedge clk);
    ins_valid_i = iv; ins_addr_i = ia; ins_idx_i = ii;
    st_valid_i = sv;  st_addr_i = sa;
    qry_valid_i = qv; qry_addr_i = qa; qry_idx_i = qi;
    exp_hit = m_query(qa, qi) && !(sv && sa == qa);
    @(posedge clk);
    #1;
    m_update(iv, ia, ii, sv, sa);
    if (qv) begin
      chk(qry_done_o === 1'b1, req, "qry_done_o", longint'(qry_done_o), 1);
      chk(qry_hit_o === exp_hit, req, "qry_hit_o", longint'(qry_hit_o), longint'(exp_hit));
      chk(squash_o === !exp_hit, req, "squash_o", longint'(squash_o), longint'(!exp_hit));
    end else begin
      // R9: no request, no result
      chk(qry_done_o === 1'b0, "R9", "qry_done_o idle", longint'(qry_done_o), 0);
    end
    // R6: full flag tracks occupancy
    chk(full_o === (m_count() == DEPTH), "R6", "full_o", longint'(full_o),
        longint'(m_count() == DEPTH));
  endtask

  task automatic ins(logic [63:0] a, logic [9:0] i);
    step(1, a, i, 0, '0, 0, '0, '0, "R11");
  endtask

  task automatic qry(logic [63:0] a, logic [9:0] i, string req);
    step(0, '0, '0, 0, '0, 1, a, i, req);
  endtask

  task automatic run_all();
    for (int k = 0; k < DEPTH; k++) begin m_v[k] = 0; m_s[k] = 0; m_a[k] = '0; m_i[k] = '0; end
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(full_o === 1'b0, "R1", "full_o", longint'(full_o), 0);
    chk(qry_done_o === 1'b0, "R1", "qry_done_o", longint'(qry_done_o), 0);
    chk(qry_hit_o === 1'b0, "R1", "qry_hit_o", longint'(qry_hit_o), 0);
    chk(squash_o === 1'b0, "R1", "squash_o", longint'(squash_o), 0);
    @(negedge clk); rst_ni = 1'b1;

    qry(aa(5), 10'd1, "R3");
    ins(aa(1), 10'd3);
    qry(aa(1), 10'd3, "R2");
    qry(aa(1), 10'd4, "R3");
    // R12: same-cycle insert not visible to query
    step(1, aa(2), 10'd0, 0, '0, 1, aa(2), 10'd0, "R12");
    qry(aa(2), 10'd0, "R2");
    // R4: store clears every index at that address
    ins(aa(1), 10'd5);
    step(0, '0, '0, 1, aa(1), 0, '0, '0, "R4");
    qry(aa(1), 10'd3, "R4");
    qry(aa(1), 10'd5, "R4");
    qry(aa(2), 10'd0, "R4");
    // R5: store and query collide
    step(0, '0, '0, 1, aa(2), 1, aa(2), 10'd0, "R5");
    qry(aa(2), 10'd0, "R5");
    // R10: insert and store collide
    step(1, aa(7), 10'd2, 1, aa(7), 0, '0, '0, "R10");
    qry(aa(7), 10'd2, "R10");

    // fill: one existing + 30 new = 31, refresh, then last slot
    for (int k = 0; k < 30; k++) ins(aa(100 + k), 10'(k));
    chk(full_o === 1'b0, "R6", "31 valid", longint'(full_o), 0);
    ins(aa(100), 10'd0);  // R8 refresh
    chk(full_o === 1'b0, "R8", "refresh uses no slot", longint'(full_o), 0);
    ins(aa(130), 10'd30);
    chk(full_o === 1'b1, "R6", "32 valid", longint'(full_o), 1);
    // R7: oldest is aa(7), then aa(101); aa(100) was refreshed
    ins(aa(200), 10'd0);
    qry(aa(7), 10'd2, "R7");
    qry(aa(101), 10'd1, "R7");
    ins(aa(201), 10'd1);
    qry(aa(101), 10'd1, "R7");
    qry(aa(100), 10'd0, "R8");
    qry(aa(102), 10'd2, "R7");
    // R11: freed slot reused without eviction
    step(0, '0, '0, 1, aa(105), 0, '0, '0, "R11");
    ins(aa(202), 10'd2);
    qry(aa(102), 10'd2, "R11");
    qry(aa(106), 10'd6, "R11");
    qry(aa(202), 10'd2, "R11");

    // random collisions over a narrow space
    for (int n = 0; n < 4000; n++) begin
      bit iv, sv, qv;
      logic [63:0] ia, sa, qa;
      logic [9:0] ii, qi;
      iv = ($urandom_range(0, 1) == 1);
      sv = ($urandom_range(0, 5) == 0);
      qv = ($urandom_range(0, 1) == 1);
      ia = aa($urandom_range(0, 13)); ii = 10'($urandom_range(0, 3));
      sa = aa($urandom_range(0, 13));
      qa = aa($urandom_range(0, 13)); qi = 10'($urandom_range(0, 3));
      step(iv, ia, ii, sv, sa, qv, qa, qi, "R2/R3 random");
    end
    step(0, '0, '0, 0, '0, 0, '0, '0, "R9");
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule